// File: doc/BRIEF.md
# OSD Character Raster Timing Generator

This block turns a dot clock and the two video sync inputs into the addressing that an on-screen-display text layer needs. From a programmable window origin, a vertical glyph scale and a gap between text rows, it works out on every dot clock whether the beam is inside a character cell. When it is, the block reports the cell's column and text row, the dot within the 12-dot-wide glyph and the scan line within the 18-line glyph. It also supplies the display RAM address of that cell, so a font ROM and a display RAM downstream can be driven directly.

Each sync input has its own polarity select. Only the selected active edge restarts the matching counter. The display RAM is assumed to return the entry for the presented address in the same cycle. The block checks every returned entry for a line-break code. When it finds one, the rest of the text row is blanked, and the next text row starts reading at the entry that follows the code.

Top module: `osd_raster_timing`

## Requirements
- R1: Each sync input has a polarity select. The value 1 makes a rising input the active edge, and 0 makes a falling input the active edge. The opposite transition restarts nothing.
- R2: The dot position within a line counts clocks, starting at 0 in the cycle after the active horizontal sync edge. Column 0, dot 0 is shown at dot position 4 × hstart.
- R3: A glyph cell is 12 dots wide. glyph_dot runs 0 to 11, then char_col increments with no gap between cells. At most COLS columns are shown per line.
- R4: The line count is the number of active horizontal sync edges since the last active vertical sync edge. Text row 0, glyph line 0 starts at line 4 × vstart. A vertical sync edge restarts row numbering.
- R5: A glyph is 18 scan lines tall. Each glyph line is repeated vsize + 1 times (vsize 0 to 3). Width is never scaled.
- R6: After the 18 × (vsize + 1) lines of a text row, 4 × row_gap blank lines follow before the next row begins. At most ROWS text rows are shown.
- R7: Outside the window, or on a blanked cell, disp_active is 0 and char_col, char_row, glyph_dot and glyph_line are 0. ram_addr is 0 whenever the beam is outside all cells.
- R8: Inside a cell, ram_addr equals the start address of the current text row plus char_col, modulo 64. Row 0 starts at address 0. Without a line break, each row starts COLS entries after the previous one.
- R9: A display RAM entry equal to 10'h03E is a line-break code. The cell holding it, and every later cell of that text row, shows disp_active 0. The next text row starts at the address after the first line-break code in the row.
- R10: After reset, disp_active and all character outputs are 0 until the first vertical and horizontal sync edges arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | input | 1 | Horizontal sync input |
| vsync | input | 1 | Vertical sync input |
| hsync_pol | input | 1 | 1: hsync active high, 0: active low |
| vsync_pol | input | 1 | 1: vsync active high, 0: active low |
| hstart | input | 6 | Window left edge in steps of 4 dots |
| vstart | input | 6 | Window top edge in steps of 4 lines |
| vsize | input | 2 | Vertical repeat of each glyph line minus one |
| row_gap | input | 2 | Blank lines between text rows, in steps of 4 |
| ram_data | input | 10 | Display RAM entry at ram_addr, same cycle |
| ram_addr | output | 6 | Display RAM address of the current cell |
| disp_active | output | 1 | Beam is on a shown character cell |
| char_col | output | $clog2(COLS+1) | Character column within the text row |
| char_row | output | $clog2(ROWS+1) | Text row number |
| glyph_dot | output | 4 | Dot within the glyph, 0 to 11 |
| glyph_line | output | 5 | Scan line within the glyph, 0 to 17 |

## Verification
A sync edge set up before a rising clock edge takes effect at that edge. The bench therefore treats the first falling edge after the clock that saw the sync as dot 0 of the new line, and every outputs-visible value is decoded from registered counters on that same cycle. The line-break decision is the exception: it also depends on ram_data, which the bench's RAM model returns combinationally for the address the block presents, so the masking is visible in the same cycle as the address. The bench drives inputs and samples outputs at falling clock edges, and predicts each cycle's values from its own count of dots and lines using division and modulo arithmetic, never by stepping counters.

// File: rtl/osd_pkg.sv
package osd_pkg;

    localparam int GLYPH_W    = 12;
    localparam int GLYPH_H    = 18;
    localparam int START_STEP = 4;
    localparam int GAP_STEP   = 4;
    localparam int ADDR_W     = 6;

    localparam logic [9:0] LINE_BREAK = 10'h03E;

    typedef enum logic {
        VPH_GLYPH = 1'b0,
        VPH_GAP   = 1'b1
    } vphase_e;

    typedef struct packed {
        logic [3:0] dot;
        logic [4:0] line;
    } glyph_pos_t;

    function automatic logic is_line_break(input logic [9:0] entry);
        return entry == LINE_BREAK;
    endfunction

    function automatic logic [3:0] gap_lines(input logic [1:0] sel);
        return {sel, 2'b00};
    endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic pol_high,
    output logic active_edge
);
    logic asserted;
    logic asserted_q;

    assign asserted    = pol_high ? sync_in : ~sync_in;
    assign active_edge = asserted & ~asserted_q;

    always_ff @(posedge clk) begin
        if (rst) asserted_q <= 1'b0;
        else     asserted_q <= asserted;
    end
endmodule

// File: rtl/osd_hcount.sv
module osd_hcount #(
    parameter int COLS  = 16,
    parameter int X_W   = 10,
    parameter int COL_W = $clog2(COLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_edge,
    input  logic [5:0]       hstart,
    output logic [3:0]       dot,
    output logic [COL_W-1:0] col,
    output logic             hwin
);
    localparam logic [COL_W-1:0] COL_END = COL_W'(COLS);
    localparam logic [3:0]       DOT_END = 4'(osd_pkg::GLYPH_W - 1);

    logic [X_W-1:0] x;
    logic [X_W-1:0] x_origin;

    assign x_origin = X_W'({hstart, 2'b00});
    assign hwin     = (x >= x_origin) && (col < COL_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            x   <= '1;
            dot <= '0;
            col <= COL_END;
        end else if (h_edge) begin
            x   <= '0;
            dot <= '0;
            col <= '0;
        end else begin
            if (x != '1) x <= x + 1'b1;
            if (hwin) begin
                if (dot == DOT_END) begin
                    dot <= '0;
                    col <= col + 1'b1;
                end else begin
                    dot <= dot + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_vcount.sv
module osd_vcount #(
    parameter int ROWS  = 4,
    parameter int Y_W   = 10,
    parameter int ROW_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_edge,
    input  logic             v_edge,
    input  logic [5:0]       vstart,
    input  logic [1:0]       vsize,
    input  logic [1:0]       row_gap,
    output logic [4:0]       gline,
    output logic [ROW_W-1:0] row,
    output logic             vwin,
    output logic             row_adv
);
    import osd_pkg::*;

    localparam logic [ROW_W-1:0] ROW_END  = ROW_W'(ROWS);
    localparam logic [4:0]       LINE_END = 5'(GLYPH_H - 1);

    logic [Y_W-1:0] y;
    logic [Y_W-1:0] y_origin;
    logic [1:0]     rep;
    logic [3:0]     gcnt;
    vphase_e        phase;
    logic           in_rows;
    logic           step;
    logic           last_rep;
    logic           last_line;
    logic           last_gap;
    logic           no_gap;

    assign y_origin  = Y_W'({vstart, 2'b00});
    assign in_rows   = (y >= y_origin) && (row < ROW_END);
    assign vwin      = in_rows && (phase == VPH_GLYPH);
    assign step      = h_edge && !v_edge && in_rows;
    assign last_rep  = (rep == vsize);
    assign last_line = (gline == LINE_END);
    assign no_gap    = (row_gap == 2'd0);
    assign last_gap  = (gcnt == gap_lines(row_gap) - 4'd1);

    always_comb begin
        row_adv = 1'b0;
        if (step) begin
            if (phase == VPH_GLYPH) row_adv = last_rep && last_line && no_gap;
            else                    row_adv = last_gap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y     <= '1;
            rep   <= '0;
            gline <= '0;
            gcnt  <= '0;
            phase <= VPH_GLYPH;
            row   <= ROW_END;
        end else if (v_edge) begin
            y     <= '0;
            rep   <= '0;
            gline <= '0;
            gcnt  <= '0;
            phase <= VPH_GLYPH;
            row   <= '0;
        end else if (h_edge) begin
            if (y != '1) y <= y + 1'b1;
            if (in_rows) begin
                if (phase == VPH_GLYPH) begin
                    if (last_rep) begin
                        rep <= '0;
                        if (last_line) begin
                            gline <= '0;
                            if (no_gap) begin
                                row <= row + 1'b1;
                            end else begin
                                phase <= VPH_GAP;
                                gcnt  <= '0;
                            end
                        end else begin
                            gline <= gline + 1'b1;
                        end
                    end else begin
                        rep <= rep + 1'b1;
                    end
                end else begin
                    if (last_gap) begin
                        phase <= VPH_GLYPH;
                        gcnt  <= '0;
                        row   <= row + 1'b1;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/osd_row_addr.sv
module osd_row_addr #(
    parameter int COLS  = 16,
    parameter int COL_W = $clog2(COLS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      h_edge,
    input  logic                      v_edge,
    input  logic                      row_adv,
    input  logic                      in_cell,
    input  logic [COL_W-1:0]          col,
    input  logic [9:0]                entry,
    output logic [osd_pkg::ADDR_W-1:0] addr,
    output logic                      blank_cell
);
    import osd_pkg::*;

    localparam logic [ADDR_W-1:0] ROW_STRIDE = ADDR_W'(COLS);

    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] next_base;
    logic              break_here;
    logic              break_in_line;
    logic              break_in_row;

    assign addr       = row_base + ADDR_W'(col);
    assign break_here = in_cell && is_line_break(entry);
    assign blank_cell = break_here || break_in_line;

    always_ff @(posedge clk) begin
        if (rst || v_edge) begin
            row_base      <= '0;
            next_base     <= '0;
            break_in_line <= 1'b0;
            break_in_row  <= 1'b0;
        end else begin
            if (h_edge)          break_in_line <= 1'b0;
            else if (break_here) break_in_line <= 1'b1;

            if (row_adv) begin
                row_base     <= break_in_row ? next_base : row_base + ROW_STRIDE;
                break_in_row <= 1'b0;
            end else if (break_here && !break_in_row) begin
                break_in_row <= 1'b1;
                next_base    <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osd_raster_timing.sv
module osd_raster_timing #(
    parameter  int COLS  = 16,
    parameter  int ROWS  = 4,
    parameter  int X_W   = 10,
    parameter  int Y_W   = 10,
    localparam int COL_W = $clog2(COLS + 1),
    localparam int ROW_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync,
    input  logic             vsync,
    input  logic             hsync_pol,
    input  logic             vsync_pol,
    input  logic [5:0]       hstart,
    input  logic [5:0]       vstart,
    input  logic [1:0]       vsize,
    input  logic [1:0]       row_gap,
    input  logic [9:0]       ram_data,
    output logic [5:0]       ram_addr,
    output logic             disp_active,
    output logic [COL_W-1:0] char_col,
    output logic [ROW_W-1:0] char_row,
    output logic [3:0]       glyph_dot,
    output logic [4:0]       glyph_line
);
    import osd_pkg::*;

    logic             h_edge;
    logic             v_edge;
    logic             hwin;
    logic             vwin;
    logic             row_adv;
    logic             in_cell;
    logic             blank_cell;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [ADDR_W-1:0] addr;
    glyph_pos_t       pos;

    osd_sync_edge u_hsync (
        .clk(clk), .rst(rst), .sync_in(hsync), .pol_high(hsync_pol), .active_edge(h_edge)
    );

    osd_sync_edge u_vsync (
        .clk(clk), .rst(rst), .sync_in(vsync), .pol_high(vsync_pol), .active_edge(v_edge)
    );

    osd_hcount #(.COLS(COLS), .X_W(X_W)) u_h (
        .clk(clk), .rst(rst), .h_edge(h_edge), .hstart(hstart),
        .dot(pos.dot), .col(col), .hwin(hwin)
    );

    osd_vcount #(.ROWS(ROWS), .Y_W(Y_W)) u_v (
        .clk(clk), .rst(rst), .h_edge(h_edge), .v_edge(v_edge),
        .vstart(vstart), .vsize(vsize), .row_gap(row_gap),
        .gline(pos.line), .row(row), .vwin(vwin), .row_adv(row_adv)
    );

    assign in_cell = hwin && vwin;

    osd_row_addr #(.COLS(COLS)) u_addr (
        .clk(clk), .rst(rst), .h_edge(h_edge), .v_edge(v_edge),
        .row_adv(row_adv), .in_cell(in_cell), .col(col), .entry(ram_data),
        .addr(addr), .blank_cell(blank_cell)
    );

    assign disp_active = in_cell && !blank_cell;
    assign ram_addr    = in_cell ? addr : '0;
    assign char_col    = disp_active ? col : '0;
    assign char_row    = disp_active ? row : '0;
    assign glyph_dot   = disp_active ? pos.dot : '0;
    assign glyph_line  = disp_active ? pos.line : '0;
endmodule

// File: rtl/osd_raster_chk.sv
module osd_raster_chk #(
    parameter  int COLS  = 16,
    parameter  int ROWS  = 4,
    localparam int COL_W = $clog2(COLS + 1),
    localparam int ROW_W = $clog2(ROWS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             h_edge,
    input logic             v_edge,
    input logic [9:0]       ram_data,
    input logic             disp_active,
    input logic [COL_W-1:0] char_col,
    input logic [ROW_W-1:0] char_row,
    input logic [3:0]       glyph_dot,
    input logic [4:0]       glyph_line
);
    a_r3_dot_below_width: assert property (@(posedge clk) disable iff (rst)
        disp_active |-> glyph_dot < 4'd12);

    a_r3_dot_steps: assert property (@(posedge clk) disable iff (rst)
        ($past(disp_active) && disp_active && !$past(h_edge) && $past(glyph_dot) != 4'd11)
        |-> (glyph_dot == $past(glyph_dot) + 4'd1 && char_col == $past(char_col)));

    a_r5_line_below_height: assert property (@(posedge clk) disable iff (rst)
        disp_active |-> glyph_line < 5'd18);

    a_r7_zero_outside: assert property (@(posedge clk) disable iff (rst)
        !disp_active |-> (char_col == '0 && char_row == '0 && glyph_dot == 4'd0 && glyph_line == 5'd0));

    a_r4_vsync_restarts_rows: assert property (@(posedge clk) disable iff (rst)
        v_edge |=> (!disp_active || char_row == '0));

    a_r9_break_never_shown: assert property (@(posedge clk) disable iff (rst)
        disp_active |-> ram_data != 10'h03E);
endmodule

bind osd_raster_timing osd_raster_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk(clk), .rst(rst), .h_edge(h_edge), .v_edge(v_edge), .ram_data(ram_data),
    .disp_active(disp_active), .char_col(char_col), .char_row(char_row),
    .glyph_dot(glyph_dot), .glyph_line(glyph_line)
);

// File: tb/tb_osd_raster_timing.sv
module tb_osd_raster_timing;
    localparam int COLS = 8;
    localparam int ROWS = 4;
    localparam logic [9:0] BRK = 10'h03E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync = 1'b0, vsync = 1'b0, hsync_pol = 1'b1, vsync_pol = 1'b1;
    logic [5:0] hstart = '0, vstart = '0;
    logic [1:0] vsize = '0, row_gap = '0;
    logic [9:0] ram_data;
    logic [5:0] ram_addr;
    logic       disp_active;
    logic [3:0] char_col;
    logic [2:0] char_row;
    logic [3:0] glyph_dot;
    logic [4:0] glyph_line;

    logic [9:0] mem [64];
    int base_tab [ROWS+1];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    assign ram_data = mem[ram_addr];

    always #10 clk = ~clk;

    osd_raster_timing #(.COLS(COLS), .ROWS(ROWS)) dut (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .hstart(hstart), .vstart(vstart),
        .vsize(vsize), .row_gap(row_gap), .ram_data(ram_data), .ram_addr(ram_addr),
        .disp_active(disp_active), .char_col(char_col), .char_row(char_row),
        .glyph_dot(glyph_dot), .glyph_line(glyph_line)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R8/R9: start address of every text row, derived from RAM contents
    task automatic build_bases();
        base_tab[0] = 0;
        for (int r = 0; r < ROWS; r++) begin
            bit found = 0;
            int nb = (base_tab[r] + COLS) % 64;
            for (int c = 0; c < COLS; c++) begin
                if (!found && mem[(base_tab[r] + c) % 64] == BRK) begin
                    found = 1;
                    nb = (base_tab[r] + c + 1) % 64;
                end
            end
            base_tab[r+1] = nb;
        end
    endtask

    task automatic calc(input int x, input int y, output int a, output int c, output int r,
                        output int d, output int l, output int ad, output bit brk);
        int hs, vs, m, pitch, dx, vp, cc, rr, rem;
        bit blocked;
        a = 0; c = 0; r = 0; d = 0; l = 0; ad = 0; brk = 0;
        hs = int'(hstart) * 4;
        vs = int'(vstart) * 4;
        m = int'(vsize) + 1;
        pitch = 18 * m + 4 * int'(row_gap);
        if (x >= hs && y >= vs) begin
            dx = x - hs; vp = y - vs;
            cc = dx / 12; rr = vp / pitch; rem = vp % pitch;
            if (cc < COLS && rr < ROWS && rem < 18 * m) begin
                ad = (base_tab[rr] + cc) % 64;
                blocked = 0;
                for (int k = 0; k <= cc; k++)
                    if (mem[(base_tab[rr] + k) % 64] == BRK) blocked = 1;
                if (blocked) brk = 1;
                else begin
                    a = 1; c = cc; r = rr; d = dx % 12; l = rem / m;
                end
            end
        end
    endtask

    task automatic check_at(input int x, input int y);
        int a, c, r, d, l, ad;
        bit brk;
        calc(x, y, a, c, r, d, l, ad, brk);
        if (brk)                      chk("R9 blanked after line break", int'(disp_active), a);
        else if (y < int'(vstart) * 4) chk("R4 above window", int'(disp_active), a);
        else                          chk("R7 window flag", int'(disp_active), a);
        chk(hsync_pol ? "R2 glyph dot" : "R1 glyph dot (falling hsync)", int'(glyph_dot), d);
        chk("R3 char column", int'(char_col), c);
        chk(vsync_pol ? "R6 text row" : "R1 text row (falling vsync)", int'(char_row), r);
        chk("R5 glyph line", int'(glyph_line), l);
        chk(brk ? "R9 address of blanked cell" : "R8 ram address", int'(ram_addr), ad);
    endtask

    task automatic run_frame(input int hs, input int vs, input int sz, input int gp,
                             input bit hp, input bit vp);
        int m, pitch, nlines, len;
        @(negedge clk);
        hsync_pol = hp; vsync_pol = vp; hsync = ~hp; vsync = ~vp;
        hstart = 6'(hs); vstart = 6'(vs); vsize = 2'(sz); row_gap = 2'(gp);
        build_bases();
        m = sz + 1;
        pitch = 18 * m + 4 * gp;
        nlines = vs * 4 + ((ROWS * pitch < 90) ? ROWS * pitch : 90) + 2;
        len = hs * 4 + COLS * 12 + 4;
        @(negedge clk); vsync = vp;
        @(negedge clk); vsync = ~vp;
        for (int ln = 1; ln <= nlines; ln++) begin
            @(negedge clk); hsync = hp;
            @(negedge clk); hsync = ~hp;
            for (int k = 0; k < len; k++) begin
                check_at(k, ln);
                if (k < len - 1) @(negedge clk);
            end
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) mem[i] = {4'($urandom), 6'($urandom % 62)};
    endtask

    initial begin
        void'($urandom(32'h0005_EED1));
        fill_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle after reset, no sync seen yet
        chk("R10 active after reset", int'(disp_active), 0);
        chk("R10 column after reset", int'(char_col), 0);
        chk("R10 row after reset", int'(char_row), 0);
        chk("R10 address after reset", int'(ram_addr), 0);
        repeat (5) @(negedge clk);
        chk("R10 still idle", int'(disp_active), 0);

        // origin at zero, single size, no gap
        run_frame(0, 0, 0, 0, 1'b1, 1'b1);
        // far right window, 4x height, widest gap, falling syncs, break in row 0
        fill_mem(); mem[2] = BRK;
        run_frame(63, 2, 3, 3, 1'b0, 0);
        // far bottom window, break at last shown column and at the first cell of row 1
        fill_mem(); mem[7] = BRK; mem[8] = BRK;
        run_frame(5, 63, 0, 1, 1'b1, 1'b0);
        // random settings
        for (int f = 0; f < 2; f++) begin
            fill_mem();
            if ($urandom % 2 == 1) mem[$urandom % 20] = BRK;
            run_frame(int'($urandom % 16), int'($urandom % 8), int'($urandom % 4),
                      int'($urandom % 4), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule